// File: doc/BRIEF.md
# Minor Frame Count Flywheel Synchronizer

This block recovers a 5-bit minor frame number from a serial overhead bit stream and locks a local frame counter to it. The demultiplexer timing supplies a word number, a strobe that marks the bit-0 slot of each word, and a pulse at each frame boundary. The block collects one field bit from each of five consecutive overhead words. On the first complete field after reset it loads its own counter from that field. From then on the counter steps once per frame boundary on its own, so downstream timing gets a clean count even when received bits are damaged.

Each later field is compared with the local count. A saturating confidence counter absorbs occasional disagreements. The block drops lock only after repeated disagreement. When lock is dropped it emits a one-cycle resync pulse and reloads from the next complete field.

Top module: `mfc_flywheel`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `mf_count` is 0, `locked` is 0 and `resync` is 0.
- R2: A bit on `ser_bit` is taken into the field only when `bit_stb` is high and `word_num` lies in 24..28. The bit from word 24 is the field MSB and the bit from word 28 is the LSB. All other bits and cycles leave the field unchanged.
- R3: The field is complete on the clock edge that samples the strobe of word 28. If the block is unlocked, the next edge after that loads `mf_count` with the field and sets `locked`.
- R4: While locked, each `frame_stb` pulse raises `mf_count` by one modulo 32, so 31 wraps to 0. While unlocked, `mf_count` holds.
- R5: While locked, a complete field is compared with `mf_count` and never reloads it. A match lowers the confidence count by one, saturating at 0. A mismatch raises it by one.
- R6: A mismatch that arrives while the confidence count already equals `MISS_LIMIT` (default 3) does three things on the same edge that would otherwise update the count. It raises `resync` for exactly one cycle, clears `locked`, and returns the confidence count to 0.
- R7: After a resync, the next complete field reloads `mf_count` and sets `locked` again, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial overhead data bit |
| bit_stb | input | 1 | High in the cycle that carries bit 0 of a word |
| word_num | input | 6 | Index of the current overhead word |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| mf_count | output | 5 | Local minor frame count |
| locked | output | 1 | Local counter is synchronized |
| resync | output | 1 | One-cycle pulse when lock is dropped |

## Verification
The bench uses the default parameters: a 5-bit field in words 24 to 28 and a mismatch limit of 3. With these values, a load of every one of the 32 field values can be swept. So can the 31-to-0 wrap and every path of the confidence counter, including runs of mismatches broken by matches that decide whether the limit is crossed. Noise bits are placed on unstrobed cycles and on words outside the field, so wrong sampling shows up as a wrong loaded value.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  // Outcome of one completed field
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LOAD  = 2'd1,
    EV_MATCH = 2'd2,
    EV_MISS  = 2'd3
  } mfc_event_e;
endpackage

// File: rtl/mfc_field_capture.sv
module mfc_field_capture #(
  parameter int FIELD_W    = 5,
  parameter int WORD_W     = 6,
  parameter int FIRST_WORD = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_stb,
  input  logic [WORD_W-1:0]  word_num,
  input  logic               ser_bit,
  output logic [FIELD_W-1:0] field,
  output logic               done
);
  localparam int LAST_WORD = FIRST_WORD + FIELD_W - 1;
  localparam logic [WORD_W-1:0] FIRST_W = WORD_W'(FIRST_WORD);
  localparam logic [WORD_W-1:0] LAST_W  = WORD_W'(LAST_WORD);

  logic [FIELD_W-1:0] shreg;
  logic [FIELD_W-1:0] shnext;
  logic               in_win;

  assign in_win = bit_stb && (word_num >= FIRST_W) && (word_num <= LAST_W);
  assign shnext = {shreg[FIELD_W-2:0], ser_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      field <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_win) begin
        shreg <= shnext;
        if (word_num == LAST_W) begin
          field <= shnext;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mfc_confidence.sv
module mfc_confidence #(
  parameter int MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic eval,
  input  logic match,
  output logic trip
);
  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(MISS_LIMIT);

  logic [CW-1:0] conf;

  assign trip = eval && !match && (conf == LIM);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      conf <= '0;
    end else if (eval) begin
      if (match) begin
        if (conf != '0) conf <= conf - 1'b1;
      end else if (trip) begin
        conf <= '0;
      end else begin
        conf <= conf + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mfc_local_counter.sv
module mfc_local_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             adv,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (adv)  count <= count + 1'b1;
  end
endmodule

// File: rtl/mfc_flywheel.sv
module mfc_flywheel #(
  parameter int FIELD_W    = 5,
  parameter int WORD_W     = 6,
  parameter int FIRST_WORD = 24,
  parameter int MISS_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_bit,
  input  logic               bit_stb,
  input  logic [WORD_W-1:0]  word_num,
  input  logic               frame_stb,
  output logic [FIELD_W-1:0] mf_count,
  output logic               locked,
  output logic               resync
);
  import mfc_pkg::*;

  logic [FIELD_W-1:0] field;
  logic               field_done;
  logic               trip;
  logic               load;
  logic               adv;
  mfc_event_e         ev;

  mfc_field_capture #(
    .FIELD_W(FIELD_W), .WORD_W(WORD_W), .FIRST_WORD(FIRST_WORD)
  ) u_cap (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .word_num(word_num),
    .ser_bit(ser_bit), .field(field), .done(field_done)
  );

  always_comb begin
    if (!field_done)          ev = EV_NONE;
    else if (!locked)         ev = EV_LOAD;
    else if (field == mf_count) ev = EV_MATCH;
    else                      ev = EV_MISS;
  end

  assign load = (ev == EV_LOAD);
  assign adv  = frame_stb && locked && !load;

  mfc_confidence #(.MISS_LIMIT(MISS_LIMIT)) u_conf (
    .clk(clk), .rst(rst), .clear(load),
    .eval(ev == EV_MATCH || ev == EV_MISS),
    .match(ev == EV_MATCH), .trip(trip)
  );

  mfc_local_counter #(.CNT_W(FIELD_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(field),
    .adv(adv), .count(mf_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      resync <= 1'b0;
    end else begin
      resync <= trip;
      if (load)      locked <= 1'b1;
      else if (trip) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/mfc_flywheel_chk.sv
module mfc_flywheel_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         frame_stb,
  input logic         field_done,
  input logic         locked,
  input logic         resync,
  input logic [W-1:0] count
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && !locked && !resync));

  p_lock_on_field_r3: assert property (@(posedge clk) disable iff (rst)
    (field_done && !locked) |=> locked);

  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (locked && frame_stb && !field_done) |=> (count == W'($past(count) + 1'b1)));

  p_hold_unlocked_r4: assert property (@(posedge clk) disable iff (rst)
    (!locked && !field_done) |=> $stable(count));

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    resync |=> !resync);

  p_unlock_on_resync_r6: assert property (@(posedge clk) disable iff (rst)
    resync |-> !locked);
endmodule

bind mfc_flywheel mfc_flywheel_chk #(.W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .field_done(field_done),
  .locked(locked), .resync(resync), .count(mf_count)
);

// File: tb/mfc_flywheel_bench.sv
`timescale 1ns/1ps
module mfc_flywheel_bench;
  localparam int LIMIT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_bit = 1'b0;
  logic       bit_stb = 1'b0;
  logic [5:0] word_num = '0;
  logic       frame_stb = 1'b0;
  logic [4:0] mf_count;
  logic       locked;
  logic       resync;

  int total = 0;
  int bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench model
  logic [4:0] m_cnt;
  logic       m_lock;
  int         m_conf;
  logic       m_rs;

  always #2.5 clk = ~clk;

  mfc_flywheel u_mfc_flywheel (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .bit_stb(bit_stb),
    .word_num(word_num), .frame_stb(frame_stb),
    .mf_count(mf_count), .locked(locked), .resync(resync)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic noise();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_stb = 1'b0; frame_stb = 1'b0;
    @(negedge clk);
    chk("R1 count", mf_count, 0);
    chk("R1 locked", locked, 0);
    chk("R1 resync", resync, 0);
    @(negedge clk); rst = 1'b0;
    m_cnt = '0; m_lock = 1'b0; m_conf = 0; m_rs = 1'b0;
  endtask

  // R2: field bits on words 24..28, MSB first; noise elsewhere
  task automatic send_field(input logic [4:0] v);
    for (int w = 20; w <= 28; w++) begin
      @(negedge clk);
      word_num = 6'(w); bit_stb = 1'b1;
      ser_bit = (w >= 24) ? v[28 - w] : noise();
      if (w != 28) begin
        @(negedge clk);
        bit_stb = 1'b0; ser_bit = noise();
      end
    end
    @(negedge clk);
    bit_stb = 1'b0; ser_bit = noise(); word_num = 6'd40;
  endtask

  task automatic do_frame(input logic [4:0] rx);
    send_field(rx);
    m_rs = 1'b0;
    if (!m_lock) begin
      m_cnt = rx; m_lock = 1'b1; m_conf = 0;
    end else if (rx == m_cnt) begin
      if (m_conf > 0) m_conf--;
    end else if (m_conf == LIMIT) begin
      m_rs = 1'b1; m_lock = 1'b0; m_conf = 0;
    end else begin
      m_conf++;
    end
    @(negedge clk);
    chk("R3/R5/R7 count", mf_count, m_cnt);
    chk("R3/R7 locked", locked, m_lock);
    chk("R6 resync", resync, m_rs);
    @(negedge clk);
    chk("R6 pulse one cycle", resync, 0);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (m_lock) m_cnt = m_cnt + 5'd1;
    chk("R4 count step", mf_count, m_cnt);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] t;
    logic [31:0] pat;
    // R1
    do_reset();
    // R2 R3: load sweep over every field value
    for (int v = 0; v < 32; v++) begin
      do_reset();
      do_frame(5'(v));
    end
    // R4: freewheel through the wrap
    do_reset();
    t = 5'd29;
    do_frame(t);
    for (int i = 0; i < 40; i++) begin
      t = t + 5'd1;
      do_frame(t);
    end
    // R5 R6 R7: mismatch patterns (1 = corrupted field)
    for (int p = 0; p < 4; p++) begin
      do_reset();
      case (p)
        0: pat = 32'b0000_0000_0000_0000_0000_0111_0000_0000; // 3 misses: tolerated
        1: pat = 32'b0000_0000_0000_0000_0001_1110_0000_0000; // 4 misses: resync
        2: pat = 32'b0000_0000_0000_0011_0111_0000_0101_0000; // mixed, crosses at end
        default: pat = 32'b0000_0000_1011_0101_1010_1101_1111_1100;
      endcase
      t = 5'(p * 7);
      do_frame(t);
      for (int i = 0; i < 32; i++) begin
        t = t + 5'd1;
        do_frame(pat[i] ? (t ^ 5'(i % 31 + 1)) : t);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule